// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches a small set of external interrupt pins (two by default), brings each into the core clock domain through a synchroniser and turns a chosen kind of transition into a pending flag per pin. One configuration bit picks the active transition for every pin at once. A 0 selects a low-to-high change and a 1 selects a high-to-low change. Each pending flag stays set until the core clears it with a per-pin clear strobe.

The block also keeps the global interrupt-enable state. Four one-cycle strobes from the instruction decoder change that state: enable, disable, return-from-interrupt, and the hardware's acceptance of an interrupt. Software can read the state through the configuration read port but cannot write it. The registered request to the core is high when any pending flag is set and the global enable is on.

Top module: `ext_irq_ctrl`

## Requirements
- R1: With the edge-select bit (cfg bit 0) at 0, a low-to-high change on any pin sets that pin's pending flag, and a high-to-low change does not.
- R2: With the edge-select bit at 1, a high-to-low change on any pin sets that pin's pending flag, and a low-to-high change does not.
- R3: One edge-select bit governs every pin. It is written through `cfg_wdata_i` bit 0 when `cfg_we_i` is high and is read back on `cfg_rdata_o` bit 0.
- R4: A pin change driven before rising clock edge N shows on `pend_o` after edge N+2, and not before.
- R5: A pending flag stays set until `pend_clr_i` for that pin is high at a clock edge, and reads 0 after that edge.
- R6: If a clear strobe and a new detected edge meet at the same clock edge, the pending flag stays set.
- R7: The global enable (`cfg_rdata_o` bit 1) becomes 1 after an edge where `ei_stb_i` or `reti_stb_i` is high and neither clearing strobe is high.
- R8: The global enable becomes 0 after an edge where `di_stb_i` or `ack_stb_i` is high. A clearing strobe overrides a setting strobe at the same edge. With no strobe high, the state holds.
- R9: A configuration write leaves the global enable unchanged, whatever value `cfg_wdata_i` bit 1 carries.
- R10: `irq_req_o` equals the global enable ANDed with the OR of all pending flags, updating at the same edge as those registers.
- R11: Changing the edge-select bit while the pins are static sets no pending flag.
- R12: After reset the global enable, all pending flags, the edge-select bit and `irq_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 2 | Write data: bit 0 edge select, bit 1 ignored |
| cfg_rdata_o | output | 2 | Read data: bit 0 edge select, bit 1 global enable |
| ei_stb_i | input | 1 | Enable-interrupts instruction strobe |
| di_stb_i | input | 1 | Disable-interrupts instruction strobe |
| reti_stb_i | input | 1 | Return-from-interrupt strobe |
| ack_stb_i | input | 1 | Hardware interrupt acceptance strobe |
| pend_clr_i | input | NUM_PINS | Per-pin pending clear strobes |
| pend_o | output | NUM_PINS | Per-pin pending flags |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
A broken synchroniser or edge detector shows up as a pending flag that sets one cycle early or late against the third clock edge, or that sets on the wrong polarity. The sweeps over pin, direction and select value catch both. A wrong global-enable register shows on read bit 1 one edge after the offending strobe pattern, and the sweep covers all sixteen strobe combinations from both starting states. A lost clear-versus-set priority shows as a flag that reads 0 at the edge where a clear and an edge meet.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CFG_W       = 2;
  localparam int CFG_SEL_BIT = 0;
  localparam int CFG_GIE_BIT = 1;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  localparam int TOP = STAGES - 1;
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[TOP];
  end

  assign lvl_o  = chain_q[TOP];
  assign prev_o = prev_q;
endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  input  logic      clr_i,
  output logic      hit_o,
  output logic      pend_nxt_o,
  output logic      pend_o
);
  logic lvl, prev, pend_q;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev)
  );

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = lvl & ~prev;
      EDGE_FALL: hit_o = ~lvl & prev;
      default:   hit_o = 1'b0;
    endcase
  end

  // a fresh edge takes priority over a clear at the same edge
  assign pend_nxt_o = hit_o | (pend_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_nxt_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ext_irq_gie.sv
module ext_irq_gie (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_nxt_o,
  output logic gie_o
);
  logic gie_q;

  always_comb begin
    if (clr_i)      gie_nxt_o = 1'b0;
    else if (set_i) gie_nxt_o = 1'b1;
    else            gie_nxt_o = gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) gie_q <= 1'b0;
    else     gie_q <= gie_nxt_o;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_wdata_i,
  output logic [1:0]          cfg_rdata_o,
  input  logic                ei_stb_i,
  input  logic                di_stb_i,
  input  logic                reti_stb_i,
  input  logic                ack_stb_i,
  input  logic [NUM_PINS-1:0] pend_clr_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                irq_req_o
);
  edge_sel_e           sel_q;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] pend_nxt;
  logic                gie, gie_nxt;
  logic                irq_q;

  always_ff @(posedge clk) begin
    if (rst)           sel_q <= EDGE_RISE;
    else if (cfg_we_i) sel_q <= edge_sel_e'(cfg_wdata_i[CFG_SEL_BIT]);
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      ext_irq_pin #(.SYNC_STAGES(SYNC_STAGES)) pin_u (
        .clk(clk), .rst(rst), .pin_i(pin_i[gi]), .sel_i(sel_q),
        .clr_i(pend_clr_i[gi]), .hit_o(edge_hit[gi]),
        .pend_nxt_o(pend_nxt[gi]), .pend_o(pend_o[gi])
      );
    end
  endgenerate

  ext_irq_gie gie_u (
    .clk(clk), .rst(rst),
    .set_i(ei_stb_i | reti_stb_i),
    .clr_i(di_stb_i | ack_stb_i),
    .gie_nxt_o(gie_nxt), .gie_o(gie)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie_nxt & (|pend_nxt);
  end

  assign irq_req_o = irq_q;

  always_comb begin
    cfg_rdata_o              = '0;
    cfg_rdata_o[CFG_SEL_BIT] = sel_q;
    cfg_rdata_o[CFG_GIE_BIT] = gie;
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int NUM_PINS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we_i,
  input logic [1:0]          cfg_rdata_o,
  input logic                ei_stb_i,
  input logic                di_stb_i,
  input logic                reti_stb_i,
  input logic                ack_stb_i,
  input logic [NUM_PINS-1:0] pend_clr_i,
  input logic [NUM_PINS-1:0] pend_o,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic                irq_req_o
);
  logic any_set, any_clr;
  assign any_set = ei_stb_i | reti_stb_i;
  assign any_clr = di_stb_i | ack_stb_i;

  assert_gie_clear_R8: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> !cfg_rdata_o[1]);
  assert_gie_set_R7: assert property (@(posedge clk) disable iff (rst)
    (any_set && !any_clr) |=> cfg_rdata_o[1]);
  assert_gie_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!any_set && !any_clr) |=> $stable(cfg_rdata_o[1]));
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (cfg_rdata_o[1] && (|pend_o)));
  assert_irq_on_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata_o[1] && (|pend_o)) |-> irq_req_o);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_chk
      assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_o[gi] && !pend_clr_i[gi]) |=> pend_o[gi]);
      assert_edge_wins_R6: assert property (@(posedge clk) disable iff (rst)
        edge_hit[gi] |=> pend_o[gi]);
      assert_pend_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o[gi]) |-> $past(edge_hit[gi]));
    end
  endgenerate
endmodule

bind ext_irq_ctrl ext_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_rdata_o(cfg_rdata_o),
  .ei_stb_i(ei_stb_i), .di_stb_i(di_stb_i), .reti_stb_i(reti_stb_i),
  .ack_stb_i(ack_stb_i), .pend_clr_i(pend_clr_i), .pend_o(pend_o),
  .edge_hit(edge_hit), .irq_req_o(irq_req_o)
);

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wdata = '0;
  logic [1:0]    cfg_rdata;
  logic          ei = 1'b0, di = 1'b0, reti = 1'b0, ack = 1'b0;
  logic [NP-1:0] clr = '0;
  logic [NP-1:0] pend;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .ei_stb_i(ei), .di_stb_i(di), .reti_stb_i(reti), .ack_stb_i(ack),
    .pend_clr_i(clr), .pend_o(pend), .irq_req_o(irq)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input logic s, input logic junk);
    cfg_we = 1'b1; cfg_wdata = {junk, s}; step(); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic set_gie(input logic g);
    if (g) ei = 1'b1; else di = 1'b1;
    step(); ei = 1'b0; di = 1'b0;
  endtask

  task automatic clear_all();
    clr = '1; step(); clr = '0;
  endtask

  initial begin
    rst = 1'b1; step(3); rst = 1'b0;
    // R12 reset state
    chk(cfg_rdata[1], 1'b0, "R12 gie");
    chk(cfg_rdata[0], 1'b0, "R12 sel");
    chk(pend[0], 1'b0, "R12 pend0");
    chk(pend[1], 1'b0, "R12 pend1");
    chk(irq, 1'b0, "R12 irq");

    // R1 R2 R3 R4 R10 sweep: select, pin, direction, enable
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < NP; p++) begin
        for (int up = 0; up < 2; up++) begin
          for (int g = 0; g < 2; g++) begin
            logic exp;
            exp = (up == 1 && s == 0) || (up == 0 && s == 1);
            set_sel(s[0], 1'b0);
            chk(cfg_rdata[0], s[0], "R3 sel readback");
            set_gie(g[0]);
            pin = up[0] ? '0 : '1;
            step(4); clear_all(); step();
            pin[p] = up[0];
            step(2);
            chk(pend[p], 1'b0, "R4 not yet");
            step();
            chk(pend[p], exp, s == 0 ? "R1 edge" : "R2 edge");
            chk(pend[1-p], 1'b0, "R3 other pin");
            chk(irq, exp & g[0], "R10 irq");
          end
        end
      end
    end

    // R5 hold and clear
    set_sel(1'b0, 1'b0); pin = '0; step(4); clear_all();
    pin[0] = 1'b1; step(3);
    chk(pend[0], 1'b1, "R5 set");
    step(5);
    chk(pend[0], 1'b1, "R5 held");
    clr[1] = 1'b1; step(); clr = '0;
    chk(pend[0], 1'b1, "R5 other clear");
    clr[0] = 1'b1; step(); clr = '0;
    chk(pend[0], 1'b0, "R5 cleared");

    // R6 clear meets fresh edge
    pin[0] = 1'b0; step(4);
    pin[0] = 1'b1; step(2);
    clr[0] = 1'b1; step(); clr = '0;
    chk(pend[0], 1'b1, "R6 edge wins");

    // R11 select toggles with pins static (high, then low)
    for (int lv = 0; lv < 2; lv++) begin
      pin = lv[0] ? '1 : '0; step(4); clear_all();
      set_sel(1'b1, 1'b0); step(4);
      set_sel(1'b0, 1'b0); step(4);
      chk(pend[0], 1'b0, "R11 pin0 static");
      chk(pend[1], 1'b0, "R11 pin1 static");
    end

    // R9 write cannot touch gie
    set_gie(1'b0); set_sel(1'b0, 1'b1);
    chk(cfg_rdata[1], 1'b0, "R9 write 1 ignored");
    set_gie(1'b1); set_sel(1'b1, 1'b0);
    chk(cfg_rdata[1], 1'b1, "R9 write 0 ignored");

    // R7 R8 sweep all strobe combinations from both states
    for (int prev = 0; prev < 2; prev++) begin
      for (int v = 0; v < 16; v++) begin
        logic exp;
        set_gie(prev[0]);
        {ei, di, reti, ack} = v[3:0];
        step();
        {ei, di, reti, ack} = 4'b0;
        if (v[2] | v[0])      exp = 1'b0;
        else if (v[3] | v[1]) exp = 1'b1;
        else                  exp = prev[0];
        chk(cfg_rdata[1], exp, exp ? "R7 gie set" : "R8 gie clear");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule